// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the serial front end of a small byte-wide memory model that sits on a shared SPI bus. A host selects it with an active-low select line, sends an 8-bit instruction MSB first, and then sends address and data bytes as that instruction needs. The block supports these operations: sequential reads that stream through the whole array, page writes, reads and writes of a status byte, and setting or clearing a write-enable latch. A pause input freezes a transaction in place while the select line stays in force. The storage is a synchronous RAM of 2048 bytes by default, and a parameter can set it to 1024 bytes.

The serial pins are oversampled by the system clock `clk`, which must run at least eight times faster than `spi_clk`. Each serial pin passes through a two-stage synchronizer, and edges of `spi_clk` are detected from the synchronized copy.

The serial control follows seven named phases:
- `ST_CMD` collects the instruction.
- `ST_ADDR` collects a 16-bit address.
- `ST_RDDATA` streams array bytes out.
- `ST_WRDATA` takes in bytes for the array.
- `ST_RDSR` streams the status byte out.
- `ST_WRSR` takes one status byte.
- `ST_SKIP` absorbs everything else until the frame ends.

The transitions are named as follows. Instruction decode moves `ST_CMD` to `ST_ADDR`, `ST_RDSR`, `ST_WRSR` or `ST_SKIP`. The sixteenth address bit moves `ST_ADDR` to `ST_RDDATA` for a read and to `ST_WRDATA` for a write. The eighth data bit moves `ST_WRSR` to `ST_SKIP`. Select going high returns any phase to `ST_CMD`.

Top module: `spi_nvm_slave`

## Requirements
- R1: The block works in clock modes 0 and 3. It samples `mosi` on rising `spi_clk` and updates `miso` after falling `spi_clk`. All fields are sent MSB first.
- R2: While `sel_n` is high, `spi_clk` and `mosi` have no effect and `miso_oe` is 0.
- R3: A rise of `sel_n` at any point aborts the instruction. The next frame is decoded from its first bit.
- R4: While `pause_n` is low and `sel_n` is low, `miso_oe` is 0 and edges on `spi_clk` and `mosi` are ignored. The transaction resumes exactly where it stopped once `pause_n` returns high.
- R5: Instruction 0x03 followed by a 16-bit address starts a read. Address bits at and above log2(DEPTH) are ignored.
- R6: A read keeps streaming while clocks continue. The address increments after each byte and wraps from DEPTH-1 to 0.
- R7: Instruction 0x06 sets the write-enable latch and instruction 0x04 clears it.
- R8: Instruction 0x02, followed by an address and data bytes, writes the array only when the latch is set. Without the latch the array stays unchanged.
- R9: Write data bytes go to consecutive addresses inside one 16-byte page. The low four address bits wrap to the start of the page.
- R10: Instruction 0x05 returns the status byte, and repeats it for as long as clocks continue. In that byte, bit 0 (write in progress) reads 0, bit 1 is the latch, and bits 7:2 are the stored user bits.
- R11: Instruction 0x01 with the latch set stores data bits 7:2 into the status byte. Bits 1:0 cannot be written. With the latch clear, the status byte is unchanged. The latch clears when select rises after a frame that wrote the array or the status byte.
- R12: After reset, the latch and the user status bits are 0 and `miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low slave select |
| spi_clk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| pause_n | input | 1 | Active-low pause of the current transaction |
| miso | output | 1 | Serial data to the host, high impedance when not enabled |
| miso_oe | output | 1 | Output enable for `miso` |

## Verification
The embedded assertions check the following on every cycle:
- a rise of select forces the instruction phase with a cleared bit counter;
- a pause keeps the phase, bit counter and address frozen;
- an array write never happens without the latch;
- the latch rises only out of instruction decode and falls only on decode or at the end of a frame.

Only the bench scenarios can show the data-level behaviour:
- correct bytes across upper-address masking, read wrap-around and page-write wrap-around;
- ignored writes without the latch;
- the status byte contents and which of its bits can be written;
- that both clock modes give the same results.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_RDDATA,
        ST_WRDATA,
        ST_RDSR,
        ST_WRSR,
        ST_SKIP
    } phase_t;

    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;

endpackage

// File: rtl/spi_nvm_sync.sv
module spi_nvm_sync #(
    parameter int WIDTH = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= RST_VAL;
            end else if (s == 0) begin
                stage_q[s] <= din;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_nvm_ram.sv
module spi_nvm_ram #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave
    import spi_nvm_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int PAGE_BYTES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic spi_clk,
    input  logic mosi,
    input  logic pause_n,
    output logic miso,
    output logic miso_oe
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(PAGE_BYTES);

    // synchronized pins: [3] select, [2] pause, [1] serial clock, [0] data
    logic [3:0] pins_s;
    logic       sel_s, pause_s, sclk_s, mosi_s, sclk_prev;

    spi_nvm_sync #(.WIDTH(4), .STAGES(2), .RST_VAL(4'b1100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sel_n, pause_n, spi_clk, mosi}),
        .dout  (pins_s)
    );

    assign {sel_s, pause_s, sclk_s, mosi_s} = pins_s;

    logic rise_evt, fall_evt, run;
    assign run      = !sel_s && pause_s;
    assign rise_evt = run && sclk_s && !sclk_prev;
    assign fall_evt = run && !sclk_s && sclk_prev;

    phase_t        state, state_d;
    logic [3:0]    bitcnt;
    logic [2:0]    ocnt;
    logic [14:0]   shreg;
    logic [AW-1:0] addr;
    logic          is_rd, wel, wr_done, so_q, oe_q;
    logic [5:0]    sr_user;
    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [7:0]    ram_wdata, rd_byte, status;
    logic [7:0]    byte_in;
    logic [15:0]   word_in;

    assign byte_in = {shreg[6:0], mosi_s};
    assign word_in = {shreg, mosi_s};
    assign status  = {sr_user, wel, 1'b0};

    spi_nvm_ram #(.DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (addr),
        .rdata (rd_byte)
    );

    // next phase
    always_comb begin
        state_d = state;
        if (sel_s) begin
            state_d = ST_CMD;
        end else if (rise_evt) begin
            unique case (state)
                ST_CMD: begin
                    if (bitcnt == 4'd7) begin
                        case (byte_in)
                            OP_READ:  state_d = ST_ADDR;
                            OP_WRITE: state_d = wel ? ST_ADDR : ST_SKIP;
                            OP_RDSR:  state_d = ST_RDSR;
                            OP_WRSR:  state_d = wel ? ST_WRSR : ST_SKIP;
                            default:  state_d = ST_SKIP;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (bitcnt == 4'd15) begin
                        state_d = is_rd ? ST_RDDATA : ST_WRDATA;
                    end
                end
                ST_WRSR: begin
                    if (bitcnt == 4'd7) begin
                        state_d = ST_SKIP;
                    end
                end
                ST_RDDATA, ST_WRDATA, ST_RDSR, ST_SKIP: state_d = state;
            endcase
        end
    end

    // phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CMD;
        end else begin
            state <= state_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            bitcnt    <= '0;
            ocnt      <= '0;
            shreg     <= '0;
            addr      <= '0;
            is_rd     <= 1'b0;
            wel       <= 1'b0;
            wr_done   <= 1'b0;
            sr_user   <= '0;
            so_q      <= 1'b0;
            oe_q      <= 1'b0;
            ram_we    <= 1'b0;
            ram_waddr <= '0;
            ram_wdata <= '0;
        end else begin
            sclk_prev <= sclk_s;
            ram_we    <= 1'b0;
            oe_q      <= run;
            if (sel_s) begin
                bitcnt <= '0;
                ocnt   <= '0;
                if (wr_done) begin
                    wel     <= 1'b0;
                    wr_done <= 1'b0;
                end
            end else if (rise_evt) begin
                shreg  <= word_in[14:0];
                bitcnt <= bitcnt + 4'd1;
                unique case (state)
                    ST_CMD: begin
                        if (bitcnt == 4'd7) begin
                            bitcnt <= '0;
                            is_rd  <= (byte_in == OP_READ);
                            if (byte_in == OP_WREN) wel <= 1'b1;
                            if (byte_in == OP_WRDI) wel <= 1'b0;
                        end
                    end
                    ST_ADDR: begin
                        if (bitcnt == 4'd15) begin
                            bitcnt <= '0;
                            addr   <= word_in[AW-1:0];
                        end
                    end
                    ST_WRDATA: begin
                        if (bitcnt == 4'd7) begin
                            bitcnt           <= '0;
                            ram_we           <= 1'b1;
                            ram_waddr        <= addr;
                            ram_wdata        <= byte_in;
                            addr[PW-1:0]     <= addr[PW-1:0] + 1'b1;
                            wr_done          <= 1'b1;
                        end
                    end
                    ST_WRSR: begin
                        if (bitcnt == 4'd7) begin
                            bitcnt  <= '0;
                            sr_user <= byte_in[7:2];
                            wr_done <= 1'b1;
                        end
                    end
                    ST_RDDATA, ST_RDSR, ST_SKIP: bitcnt <= '0;
                endcase
            end else if (fall_evt) begin
                if (state == ST_RDDATA) begin
                    so_q <= rd_byte[~ocnt];
                    ocnt <= ocnt + 3'd1;
                    if (ocnt == 3'd7) addr <= addr + 1'b1;
                end else if (state == ST_RDSR) begin
                    so_q <= status[~ocnt];
                    ocnt <= ocnt + 3'd1;
                end
            end
        end
    end

    assign miso_oe = oe_q;
    assign miso    = oe_q ? so_q : 1'bz;

    // R3
    abort_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> (state == ST_CMD) && (bitcnt == 4'd0));

    // R4
    pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s && !pause_s) |=> $stable(state) && $stable(bitcnt) && $stable(addr));

    // R8
    write_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> wel);

    // R7
    wel_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> ($past(state) == ST_CMD));

    // R11
    wel_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel) |-> ($past(sel_s) || ($past(state) == ST_CMD)));

endmodule

// File: tb/spi_nvm_slave_test.sv
module spi_nvm_slave_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic spi_clk = 1'b0;
    logic mosi = 1'b0;
    logic pause_n = 1'b1;
    logic mode3 = 1'b0;
    wire  miso;
    wire  miso_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_nvm_slave uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .spi_clk (spi_clk),
        .mosi    (mosi),
        .pause_n (pause_n),
        .miso    (miso),
        .miso_oe (miso_oe)
    );

    // {write address, read address, data}
    localparam logic [39:0] VEC [6] = '{
        {16'h0000, 16'h0000, 8'hA5},
        {16'h0123, 16'h0123, 8'h3C},
        {16'hF805, 16'h0005, 8'h77},
        {16'h07FF, 16'h07FF, 8'hE1},
        {16'h0400, 16'hFC00, 8'h5A},
        {16'h0010, 16'h0010, 8'h0F}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (mode3) spi_clk = 1'b0;
            mosi = tx[i];
            wait_clk(8);
            rx[i] = miso;
            spi_clk = 1'b1;
            wait_clk(8);
            if (!mode3) spi_clk = 1'b0;
        end
    endtask

    task automatic frame_start;
        spi_clk = mode3;
        wait_clk(4);
        sel_n = 1'b0;
        wait_clk(8);
    endtask

    task automatic frame_end;
        wait_clk(8);
        sel_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic send_op(input logic [7:0] op);
        logic [7:0] rx;
        frame_start();
        xfer(op, 8, rx);
        frame_end();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] rx;
        frame_start();
        xfer(8'h05, 8, rx);
        xfer(8'h00, 8, s);
        frame_end();
    endtask

    task automatic write1(input logic [15:0] a, input logic [7:0] d, input bit en);
        logic [7:0] rx;
        if (en) send_op(8'h06);
        frame_start();
        xfer(8'h02, 8, rx);
        xfer(a[15:8], 8, rx);
        xfer(a[7:0], 8, rx);
        xfer(d, 8, rx);
        frame_end();
    endtask

    task automatic read2(input logic [15:0] a, output logic [7:0] b0, output logic [7:0] b1);
        logic [7:0] rx;
        frame_start();
        xfer(8'h03, 8, rx);
        xfer(a[15:8], 8, rx);
        xfer(a[7:0], 8, rx);
        xfer(8'h00, 8, b0);
        xfer(8'h00, 8, b1);
        frame_end();
    endtask

    initial begin
        wait_clk(150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, b0, b1, rx;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R12 reset state
        check("R12 oe after reset", {7'd0, miso_oe}, 8'h00);
        rdsr(s);
        check("R12 R10 status after reset", s, 8'h00);

        // R5 R8 table of write/readback vectors
        for (int v = 0; v < 6; v++) begin
            write1(VEC[v][39:24], VEC[v][7:0], 1'b1);
            read2(VEC[v][23:8], b0, b1);
            check("R5 R8 readback", b0, VEC[v][7:0]);
        end

        // R7 latch set and clear, R10 repeated status
        send_op(8'h06);
        frame_start();
        xfer(8'h05, 8, rx);
        xfer(8'h00, 8, b0);
        xfer(8'h00, 8, b1);
        frame_end();
        check("R7 latch set", b0, 8'h02);
        check("R10 status repeats", b1, 8'h02);
        send_op(8'h04);
        rdsr(s);
        check("R7 latch cleared", s, 8'h00);

        // R8 write without latch ignored
        write1(16'h0000, 8'h11, 1'b0);
        read2(16'h0000, b0, b1);
        check("R8 write without latch", b0, 8'hA5);

        // R11 status write and protected bits
        send_op(8'h06);
        frame_start();
        xfer(8'h01, 8, rx);
        xfer(8'hFF, 8, rx);
        frame_end();
        rdsr(s);
        check("R11 status write", s, 8'hFC);
        frame_start();
        xfer(8'h01, 8, rx);
        xfer(8'h00, 8, rx);
        frame_end();
        rdsr(s);
        check("R11 status write without latch", s, 8'hFC);
        send_op(8'h06);
        frame_start();
        xfer(8'h01, 8, rx);
        xfer(8'h00, 8, rx);
        frame_end();
        rdsr(s);
        check("R11 status restore", s, 8'h00);

        // R9 page wrap
        send_op(8'h06);
        frame_start();
        xfer(8'h02, 8, rx);
        xfer(8'h00, 8, rx);
        xfer(8'h1E, 8, rx);
        xfer(8'h21, 8, rx);
        xfer(8'h22, 8, rx);
        xfer(8'h23, 8, rx);
        frame_end();
        read2(16'h001E, b0, b1);
        check("R9 page byte 0", b0, 8'h21);
        check("R9 page byte 1", b1, 8'h22);
        read2(16'h0010, b0, b1);
        check("R9 page wrap", b0, 8'h23);

        // R6 sequential read wrap to address 0
        read2(16'h07FF, b0, b1);
        check("R6 last byte", b0, 8'hE1);
        check("R6 wrap to zero", b1, 8'hA5);

        // R4 pause in the middle of the address
        frame_start();
        xfer(8'h03, 8, rx);
        xfer(8'h01, 8, rx);
        pause_n = 1'b0;
        wait_clk(8);
        check("R4 oe during pause", {7'd0, miso_oe}, 8'h00);
        for (int k = 0; k < 4; k++) begin
            mosi = k[0];
            spi_clk = 1'b1;
            wait_clk(8);
            spi_clk = 1'b0;
            wait_clk(8);
        end
        pause_n = 1'b1;
        wait_clk(8);
        xfer(8'h23, 8, rx);
        xfer(8'h00, 8, b0);
        frame_end();
        check("R4 resume after pause", b0, 8'h3C);

        // R3 abort mid instruction
        frame_start();
        xfer(8'h06, 5, rx);
        frame_end();
        send_op(8'h06);
        rdsr(s);
        check("R3 decode after abort", s, 8'h02);
        send_op(8'h04);

        // R2 bus ignored while deselected
        for (int i = 7; i >= 0; i--) begin
            mosi = i[0] ? 1'b1 : (i == 2);
            wait_clk(8);
            spi_clk = 1'b1;
            wait_clk(8);
            spi_clk = 1'b0;
        end
        check("R2 oe while deselected", {7'd0, miso_oe}, 8'h00);
        rdsr(s);
        check("R2 no latch change while deselected", s, 8'h00);

        // R1 clock mode 3
        mode3 = 1'b1;
        read2(16'h0005, b0, b1);
        check("R1 mode3 read", b0, 8'h77);
        send_op(8'h06);
        rdsr(s);
        check("R1 mode3 status", s, 8'h02);
        send_op(8'h04);
        mode3 = 1'b0;
        spi_clk = 1'b0;
        wait_clk(8);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule